// File: doc/BRIEF.md
# Nibble-Wide General-Purpose I/O Bank

This block holds five groups of four bidirectional pins behind a plain register bus. The bus has an address, write data, a write strobe and combinational read data. Each group has two registers: a data latch and a direction register. One bit turns on the pull-up resistors for the whole bank. A separate 4-bit register moves pins of the last group over to the analog converter. Pin levels arrive already synchronized. For every pin the block produces an output value, an output enable and a pull-up enable. For the last group it also produces the four analog-channel selects.

When a pin is an output, reading its data register returns the latch. When it is an input, the read returns the live pin level. A pin can be taken over, either by a serial or other peripheral through the per-group ownership inputs, or by the converter through the analog-select register. Its latch then becomes plain storage, and the block stops driving and pulling that pin.

Top module: `nibble_gpio_bank`

## Requirements
- R1: After reset, every data latch, direction register, the pull-up bit and the analog-select register read 0. As a result pinOe, pinOut, pinPullUp and anaSel are all 0.
- R2: The address map is fixed:
  - Group p's data register is at 0xF42 + 4·p, for p = 0..4.
  - Its direction register (1 = output) is at the address one below.
  - The pull-up bit is bit 0 of 0xF40.
  - The analog-select register is at 0xFD1.
  - Bit n of a group register maps to pin index 4·p + n of the flat pin vectors.
- R3: A pin that is an output and not taken over has pinOe = 1 and pinOut equal to its latch bit.
- R4: A data latch accepts writes while its pin is an input. The stored value drives the pin once the direction becomes output.
- R5: Reading a data register returns pinIn for pins in input mode and the latch for pins in output mode, bit by bit.
- R6: pinPullUp for a pin is 1 only when the pull-up bit is 1, the pin is an input and the pin is not taken over. Pins of group 4 never get a pull-up.
- R7: anaSel equals the analog-select register, and that register reads back. A group-4 pin whose select bit is 1 has pinOe = 0 and pinOut = 0, and its data register bit reads the latch.
- R8: When periphOwn[p] is 1, all pins of group p have pinOe = 0, pinOut = 0 and pinPullUp = 0. Their data register reads and writes the latch as plain storage.
- R9: Reads of any unmapped address return 0, and writes to an unmapped address change no register.
- R10: A register write takes effect at the clock edge that samples busWe, and not before. Read data is combinational from the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register word address |
| busWdata | input | 4 | Write data |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busRdata | output | 4 | Read data for busAddr |
| pinIn | input | 20 | Synchronized pin levels, pin 4·p+n |
| periphOwn | input | 5 | Per-group peripheral takeover |
| pinOut | output | 20 | Output value per pin |
| pinOe | output | 20 | Output enable per pin |
| pinPullUp | output | 20 | Pull-up enable per pin |
| anaSel | output | 4 | Analog-channel select for group 4 |

## Verification
Read data depends only on the current address, the registers and pinIn. The bench therefore samples busRdata one nanosecond after driving the address, in the same cycle. Register writes need one rising edge. Every write in the bench is applied at a falling edge, and its effect is checked only from the next falling edge onward. pinOe, pinOut, pinPullUp and anaSel are combinational from the registers, pinIn and periphOwn. They are checked one nanosecond after an ownership change, or one half-cycle after the edge that wrote a register. The latency test for R10 samples pinOut both before and after the capturing edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_PORTS   = 5;
  localparam int PORT_W      = 4;
  localparam int ADDR_W      = 12;
  localparam int PIN_W       = NUM_PORTS * PORT_W;
  localparam int PORT_IDX_W  = $clog2(NUM_PORTS);
  localparam int PORT_STRIDE = 4;
  localparam int ANA_PORT    = NUM_PORTS - 1;

  localparam logic [ADDR_W-1:0] DATA_BASE = 12'hF42;
  localparam logic [ADDR_W-1:0] PULL_ADDR = 12'hF40;
  localparam logic [ADDR_W-1:0] ANA_ADDR  = 12'hFD1;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DATA,
    RD_DIR,
    RD_PULL,
    RD_ANA
  } rdSrc_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0]  dataWe;
    logic [NUM_PORTS-1:0]  dirWe;
    logic                  pullWe;
    logic                  anaWe;
    rdSrc_e                rdSrc;
    logic [PORT_IDX_W-1:0] rdPort;
  } regStrobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe        = '0;
    strobe.rdSrc  = RD_NONE;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (busAddr == DATA_BASE + ADDR_W'(p * PORT_STRIDE)) begin
        strobe.rdSrc     = RD_DATA;
        strobe.rdPort    = PORT_IDX_W'(p);
        strobe.dataWe[p] = busWe;
      end else if (busAddr == DATA_BASE + ADDR_W'(p * PORT_STRIDE) - ADDR_W'(1)) begin
        strobe.rdSrc    = RD_DIR;
        strobe.rdPort   = PORT_IDX_W'(p);
        strobe.dirWe[p] = busWe;
      end
    end
    if (busAddr == PULL_ADDR) begin
      strobe.rdSrc  = RD_PULL;
      strobe.pullWe = busWe;
    end
    if (busAddr == ANA_ADDR) begin
      strobe.rdSrc = RD_ANA;
      strobe.anaWe = busWe;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.dataWe, strobe.dirWe, strobe.pullWe, strobe.anaWe})); // R2

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSrc == RD_NONE) |->
      ({strobe.dataWe, strobe.dirWe, strobe.pullWe, strobe.anaWe} == '0)); // R9

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [PORT_W-1:0]    busWdata,
  input  logic [PIN_W-1:0]     pinIn,
  input  logic [NUM_PORTS-1:0] periphOwn,
  output logic [PORT_W-1:0]    busRdata,
  output logic [PIN_W-1:0]     pinOut,
  output logic [PIN_W-1:0]     pinOe,
  output logic [PIN_W-1:0]     pinPullUp,
  output logic [PORT_W-1:0]    anaSel
);

  logic [NUM_PORTS-1:0][PORT_W-1:0] dataLat;
  logic [NUM_PORTS-1:0][PORT_W-1:0] dirReg;
  logic [NUM_PORTS-1:0][PORT_W-1:0] readVal;
  logic [NUM_PORTS-1:0][PORT_W-1:0] takenPin;
  logic                             pullReg;
  logic [PORT_W-1:0]                anaReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pullReg <= 1'b0;
      anaReg  <= '0;
    end else begin
      if (strobe.pullWe) pullReg <= busWdata[0];
      if (strobe.anaWe)  anaReg  <= busWdata;
    end
  end

  assign anaSel = anaReg;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataLat[p] <= '0;
        dirReg[p]  <= '0;
      end else begin
        if (strobe.dataWe[p]) dataLat[p] <= busWdata;
        if (strobe.dirWe[p])  dirReg[p]  <= busWdata;
      end
    end

    if (p == ANA_PORT) begin : g_ana
      assign takenPin[p] = {PORT_W{periphOwn[p]}} | anaReg;
    end else begin : g_dig
      assign takenPin[p] = {PORT_W{periphOwn[p]}};
    end

    for (genvar n = 0; n < PORT_W; n++) begin : g_pin
      localparam int PIN = p * PORT_W + n;
      assign pinOe[PIN]  = dirReg[p][n] & ~takenPin[p][n];
      assign pinOut[PIN] = dataLat[p][n] & ~takenPin[p][n];
      assign readVal[p][n] = (takenPin[p][n] | dirReg[p][n]) ? dataLat[p][n] : pinIn[PIN];
      if (p == ANA_PORT) begin : g_nopull
        assign pinPullUp[PIN] = 1'b0;
      end else begin : g_pull
        assign pinPullUp[PIN] = pullReg & ~dirReg[p][n] & ~takenPin[p][n];
      end
    end

    AST_DATA_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.dataWe[p] |=> (dataLat[p] == $past(busWdata))); // R4

    AST_OWNED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      periphOwn[p] |-> (pinOe[p*PORT_W +: PORT_W] == '0 &&
                        pinPullUp[p*PORT_W +: PORT_W] == '0)); // R8
  end

  always_comb begin
    busRdata = '0;
    case (strobe.rdSrc)
      RD_DATA: busRdata = readVal[strobe.rdPort];
      RD_DIR:  busRdata = dirReg[strobe.rdPort];
      RD_PULL: busRdata = {{(PORT_W-1){1'b0}}, pullReg};
      RD_ANA:  busRdata = anaReg;
      default: busRdata = '0;
    endcase
  end

  AST_ANA_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (anaSel & pinOe[ANA_PORT*PORT_W +: PORT_W]) == '0); // R7

  AST_NO_PULL_LAST: assert property (@(posedge clk) disable iff (!rstN)
    pinPullUp[ANA_PORT*PORT_W +: PORT_W] == '0); // R6

  AST_PULL_NOT_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (pinPullUp & pinOe) == '0); // R6

endmodule

// File: rtl/nibble_gpio_bank.sv
module nibble_gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [PORT_W-1:0]    busWdata,
  input  logic                 busWe,
  output logic [PORT_W-1:0]    busRdata,
  input  logic [PIN_W-1:0]     pinIn,
  input  logic [NUM_PORTS-1:0] periphOwn,
  output logic [PIN_W-1:0]     pinOut,
  output logic [PIN_W-1:0]     pinOe,
  output logic [PIN_W-1:0]     pinPullUp,
  output logic [PORT_W-1:0]    anaSel
);

  regStrobe_t strobe;

  gpio_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe)
  );

  gpio_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .pinIn     (pinIn),
    .periphOwn (periphOwn),
    .busRdata  (busRdata),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pinPullUp (pinPullUp),
    .anaSel    (anaSel)
  );

endmodule

// File: tb/nibble_gpio_bank_bench.sv
`timescale 1ns/1ps
module nibble_gpio_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [3:0]  busWdata = '0;
  logic        busWe = 1'b0;
  logic [3:0]  busRdata;
  logic [19:0] pinIn = 20'h5A3C9;
  logic [4:0]  periphOwn = '0;
  logic [19:0] pinOut, pinOe, pinPullUp;
  logic [3:0]  anaSel;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  nibble_gpio_bank u_nibble_gpio_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .pinIn(pinIn), .periphOwn(periphOwn),
    .pinOut(pinOut), .pinOe(pinOe), .pinPullUp(pinPullUp), .anaSel(anaSel)
  );

  // {we, addr, wdata, expected read, requirement number}
  localparam int NV = 24;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 12'hF42, 4'h0, 4'h9, 4'd5},  // R5 input reads pin
    {1'b1, 12'hF42, 4'h6, 4'h0, 4'd4},
    {1'b0, 12'hF42, 4'h0, 4'h9, 4'd4},  // R4 latch hidden while input
    {1'b1, 12'hF41, 4'hF, 4'h0, 4'd2},
    {1'b0, 12'hF42, 4'h0, 4'h6, 4'd4},  // R4 latch visible as output
    {1'b1, 12'hF41, 4'h3, 4'h0, 4'd2},
    {1'b0, 12'hF42, 4'h0, 4'hA, 4'd5},  // R5 mixed direction
    {1'b0, 12'hF41, 4'h0, 4'h3, 4'd2},  // R2 direction reads back
    {1'b1, 12'hF46, 4'h5, 4'h0, 4'd2},
    {1'b1, 12'hF45, 4'hF, 4'h0, 4'd2},
    {1'b0, 12'hF46, 4'h0, 4'h5, 4'd2},  // R2 group 1 map
    {1'b1, 12'hF52, 4'hC, 4'h0, 4'd2},
    {1'b0, 12'hF52, 4'h0, 4'h5, 4'd5},  // R5 group 4 input
    {1'b1, 12'hF51, 4'hF, 4'h0, 4'd2},
    {1'b0, 12'hF52, 4'h0, 4'hC, 4'd2},  // R2 group 4 map
    {1'b1, 12'hF40, 4'hF, 4'h0, 4'd6},
    {1'b0, 12'hF40, 4'h0, 4'h1, 4'd6},  // R6 pull-up bit only bit 0
    {1'b1, 12'hFD1, 4'h3, 4'h0, 4'd7},
    {1'b0, 12'hFD1, 4'h0, 4'h3, 4'd7},  // R7 select reads back
    {1'b0, 12'hF43, 4'h0, 4'h0, 4'd9},  // R9 hole between groups
    {1'b1, 12'hF43, 4'hF, 4'h0, 4'd9},
    {1'b0, 12'hF43, 4'h0, 4'h0, 4'd9},  // R9 write ignored
    {1'b0, 12'hF56, 4'h0, 4'h0, 4'd9},  // R9 past last group
    {1'b0, 12'hF4A, 4'h0, 4'h3, 4'd5}   // R5 group 2 input
  };

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busOp(logic we, logic [11:0] addr, logic [3:0] wd);
    @(negedge clk);
    busWe = we; busAddr = addr; busWdata = wd;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 pinOe", pinOe, 20'h0);
    check("R1 pinOut", pinOut, 20'h0);
    check("R1 pinPullUp", pinPullUp, 20'h0);
    check("R1 anaSel", {16'h0, anaSel}, 20'h0);

    for (int i = 0; i < NV; i++) begin
      busOp(VEC[i][24], VEC[i][23:12], VEC[i][11:8]);
      if (!VEC[i][24])
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), {16'h0, busRdata}, {16'h0, VEC[i][7:4]});
    end
    busOp(1'b0, 12'h000, 4'h0);

    check("R3 pinOe", pinOe, 20'hC00F3);
    check("R3 pinOut", pinOut, 20'hC0056);
    check("R6 pinPullUp", pinPullUp, 20'h0FF0C);
    check("R7 anaSel", {16'h0, anaSel}, 20'h3);
    busOp(1'b0, 12'hF52, 4'h0);
    check("R7 analog pin reads latch", {16'h0, busRdata}, 20'hC);
    busOp(1'b1, 12'hF52, 4'hF);
    busOp(1'b0, 12'hF52, 4'h0);
    check("R7 analog latch storage", {16'h0, busRdata}, 20'hF);
    check("R7 analog pins undriven", pinOut, 20'hC0056);

    periphOwn = 5'b00100;
    #1;
    check("R8 no pull on owned group", pinPullUp, 20'h0F00C);
    busOp(1'b0, 12'hF4A, 4'h0);
    check("R8 owned reads latch", {16'h0, busRdata}, 20'h0);
    busOp(1'b1, 12'hF4A, 4'h9);
    busOp(1'b0, 12'hF4A, 4'h0);
    check("R8 owned latch storage", {16'h0, busRdata}, 20'h9);
    check("R8 owned pin not driven", pinOut, 20'hC0056);
    periphOwn = 5'b00000;

    busOp(1'b1, 12'hF42, 4'h1);
    check("R10 before edge", {16'h0, pinOut[3:0]}, 20'h6);
    busOp(1'b0, 12'h000, 4'h0);
    check("R10 after edge", {16'h0, pinOut[3:0]}, 20'h1);

    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 pinOe after reset", pinOe, 20'h0);
    check("R1 pinPullUp after reset", pinPullUp, 20'h0);
    check("R1 anaSel after reset", {16'h0, anaSel}, 20'h0);
    busOp(1'b0, 12'hF42, 4'h0);
    check("R1 data reads pin after reset", {16'h0, busRdata}, 20'h9);
    busOp(1'b0, 12'hF51, 4'h0);
    check("R1 direction cleared", {16'h0, busRdata}, 20'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule